// File: doc/BRIEF.md
# Three-Valued Gate Deduction Cell

This combinational cell works on one two-input logic gate whose signals are only partly known. It takes input A, input B and output Z of the gate. Each signal is 0, 1 or unknown. It returns the most fully determined state that agrees with the selected gate function, which is AND, OR or XOR. Values propagate both ways. Known inputs fix the output, and a known output constrains the inputs. A state that no real gate could reach is reported as a contradiction.

A larger solver would call the cell repeatedly on the gates of a netlist. It would use the change flag to tell whether a pass learned anything and the error flag to drop an impossible branch. The cell has no clock and no storage. Its outputs follow its inputs in the same evaluation, so it has no valid/ready handshake: data is presented and read as plain levels.

Top module: `tdl_cell`

## Requirements
- R1: Every signal uses a 2-bit code: 2'b00 is unknown, 2'b10 is logic 0 and 2'b11 is logic 1. An input code of 2'b01 is illegal and is reported as an error when a gate function is selected. No output is ever 2'b01.
- R2: With gate_op = 0 (AND), the following deductions apply. An input at 0 forces Z to 0. Z at 1 forces both inputs to 1. Z at 0 with one input at 1 forces the other input to 0. Both inputs at 1 force Z to 1.
- R3: With gate_op = 1 (OR), the following deductions apply. An input at 1 forces Z to 1. Z at 0 forces both inputs to 0. Z at 1 with one input at 0 forces the other input to 1. Both inputs at 0 force Z to 0.
- R4: With gate_op = 2 (XOR), any two known signals fix the third. One known signal alone gives no deduction. Three known signals with an odd count of ones are a contradiction.
- R5: A contradictory state sets err_o = 1 and chg_o = 1, and all three outputs are unknown (2'b00).
- R6: When there is no error, chg_o is 1 exactly when at least one output code differs from its input code. An all-unknown input returns all-unknown with both flags at 0.
- R7: gate_op = 3 returns the three input codes unchanged, with err_o = 0 and chg_o = 0, whatever the codes are.
- R8: The result is maximal. An output signal is known exactly when all binary completions of the input that satisfy the gate agree on that signal. An error is reported exactly when no such completion exists.
- R9: When there is no error, every signal that was known on input keeps its value on output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gate_op | input | 2 | Function select: 0 AND, 1 OR, 2 XOR, 3 pass-through |
| a_in | input | 2 | Code of gate input A |
| b_in | input | 2 | Code of gate input B |
| z_in | input | 2 | Code of gate output Z |
| a_out | output | 2 | Deduced code of A |
| b_out | output | 2 | Deduced code of B |
| z_out | output | 2 | Deduced code of Z |
| err_o | output | 1 | Contradiction or illegal code seen |
| chg_o | output | 1 | Result differs from the supplied state |

## Verification
Two functions can coincide in one evaluation. An illegal 2'b01 code can sit on one signal while the other two signals already form a contradiction. A contradiction is also always reported together with a change. The bench provokes both cases by sweeping every legal triple under each function and by drawing random raw 2-bit codes, illegal ones included. For each result it checks that exactly one error is reported, that the triple is blanked, and that the change flag is raised. The expected result comes from brute-force enumeration of the eight binary completions, not from the deduction rules.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int TRIT_W = 2;
  localparam int NSIG   = 3;
  localparam int OP_W   = 2;
  localparam logic [TRIT_W-1:0] T_UNK = 2'b00;
  localparam logic [TRIT_W-1:0] T_BAD = 2'b01;
  localparam logic [TRIT_W-1:0] T_ZERO = 2'b10;
  localparam logic [TRIT_W-1:0] T_ONE = 2'b11;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_PASS = 2'd3
  } gate_op_e;

  function automatic logic [TRIT_W-1:0] enc_trit(input logic kn, input logic v);
    return kn ? {1'b1, v} : T_UNK;
  endfunction
endpackage

// File: rtl/tdl_decode.sv
module tdl_decode
  import tdl_pkg::*;
(
  input  logic [TRIT_W-1:0] code,
  output logic              known,
  output logic              val,
  output logic              bad
);
  assign known = code[1];
  assign val   = code[0];
  assign bad   = (code == T_BAD);
endmodule

// File: rtl/tdl_ctrl_rule.sv
// Deduction for gates with a controlling input value: CTRL = 0 gives AND,
// CTRL = 1 gives OR. Index 0 = A, 1 = B, 2 = Z.
module tdl_ctrl_rule
  import tdl_pkg::*;
#(
  parameter logic CTRL = 1'b0
) (
  input  logic [NSIG-1:0] kn_i,
  input  logic [NSIG-1:0] vl_i,
  output logic [NSIG-1:0] kn_o,
  output logic [NSIG-1:0] vl_o,
  output logic            contra
);
  logic [NSIG-1:0] is_c, is_n;

  always_comb begin
    for (int i = 0; i < NSIG; i++) begin
      is_c[i] = kn_i[i] && (vl_i[i] == CTRL);
      is_n[i] = kn_i[i] && (vl_i[i] != CTRL);
    end
    contra = ((is_c[0] || is_c[1]) && is_n[2]) ||
             (is_n[0] && is_n[1] && is_c[2]);
    kn_o = kn_i;
    vl_o = vl_i;
    if (is_c[0] || is_c[1]) begin
      kn_o[2] = 1'b1; vl_o[2] = CTRL;
    end
    if (is_n[0] && is_n[1]) begin
      kn_o[2] = 1'b1; vl_o[2] = ~CTRL;
    end
    if (is_n[2]) begin
      kn_o[0] = 1'b1; vl_o[0] = ~CTRL;
      kn_o[1] = 1'b1; vl_o[1] = ~CTRL;
    end
    if (is_c[2] && is_n[0]) begin
      kn_o[1] = 1'b1; vl_o[1] = CTRL;
    end
    if (is_c[2] && is_n[1]) begin
      kn_o[0] = 1'b1; vl_o[0] = CTRL;
    end
  end

  // A non-controlling output must drive both inputs to the non-controlling value
  always_comb begin
    if (!contra && is_n[2])
      assert_ctrl_backprop_R2: assert (kn_o[1:0] == 2'b11 && vl_o[1:0] == {2{~CTRL}})
        else $error("backward rule broken (R2/R3)");
  end
endmodule

// File: rtl/tdl_xor_rule.sv
module tdl_xor_rule
  import tdl_pkg::*;
(
  input  logic [NSIG-1:0] kn_i,
  input  logic [NSIG-1:0] vl_i,
  output logic [NSIG-1:0] kn_o,
  output logic [NSIG-1:0] vl_o,
  output logic            contra
);
  localparam int CNT_W = $clog2(NSIG + 1);
  logic [CNT_W-1:0] nk;
  logic             par;

  always_comb begin
    nk  = '0;
    par = 1'b0;
    for (int i = 0; i < NSIG; i++) begin
      nk  = nk + CNT_W'(kn_i[i]);
      par = par ^ (kn_i[i] & vl_i[i]);
    end
    kn_o   = kn_i;
    vl_o   = vl_i;
    contra = (nk == CNT_W'(NSIG)) && par;
    if (nk == CNT_W'(NSIG - 1)) begin
      for (int i = 0; i < NSIG; i++) begin
        if (!kn_i[i]) begin
          kn_o[i] = 1'b1;
          vl_o[i] = par;
        end
      end
    end
  end

  always_comb begin
    if (nk == CNT_W'(NSIG - 1))
      assert_xor_fill_R4: assert (&kn_o && !contra) else $error("xor fill missing (R4)");
    if (nk == CNT_W'(1))
      assert_xor_single_R4: assert (kn_o == kn_i) else $error("xor deduced from one signal (R4)");
  end
endmodule

// File: rtl/tdl_cell.sv
module tdl_cell
  import tdl_pkg::*;
(
  input  logic [1:0] gate_op,
  input  logic [1:0] a_in,
  input  logic [1:0] b_in,
  input  logic [1:0] z_in,
  output logic [1:0] a_out,
  output logic [1:0] b_out,
  output logic [1:0] z_out,
  output logic       err_o,
  output logic       chg_o
);
  logic [TRIT_W-1:0] tin  [NSIG];
  logic [TRIT_W-1:0] tout [NSIG];
  logic [NSIG-1:0]   kn, vl, bad;
  logic [NSIG-1:0]   and_kn, and_vl, or_kn, or_vl, xor_kn, xor_vl;
  logic              and_c, or_c, xor_c;
  logic [NSIG-1:0]   sel_kn, sel_vl;
  logic              sel_c, diff;
  gate_op_e          op;

  assign tin[0] = a_in;
  assign tin[1] = b_in;
  assign tin[2] = z_in;
  assign op     = gate_op_e'(gate_op);

  for (genvar g = 0; g < NSIG; g++) begin : g_dec
    tdl_decode u_dec (.code(tin[g]), .known(kn[g]), .val(vl[g]), .bad(bad[g]));
  end

  tdl_ctrl_rule #(.CTRL(1'b0)) u_and (
    .kn_i(kn), .vl_i(vl), .kn_o(and_kn), .vl_o(and_vl), .contra(and_c));
  tdl_ctrl_rule #(.CTRL(1'b1)) u_or (
    .kn_i(kn), .vl_i(vl), .kn_o(or_kn), .vl_o(or_vl), .contra(or_c));
  tdl_xor_rule u_xor (
    .kn_i(kn), .vl_i(vl), .kn_o(xor_kn), .vl_o(xor_vl), .contra(xor_c));

  always_comb begin
    case (op)
      OP_AND:  begin sel_kn = and_kn; sel_vl = and_vl; sel_c = and_c; end
      OP_OR:   begin sel_kn = or_kn;  sel_vl = or_vl;  sel_c = or_c;  end
      OP_XOR:  begin sel_kn = xor_kn; sel_vl = xor_vl; sel_c = xor_c; end
      default: begin sel_kn = kn;     sel_vl = vl;     sel_c = 1'b0;  end
    endcase
    err_o = (op != OP_PASS) && (sel_c || (|bad));
    diff  = 1'b0;
    for (int i = 0; i < NSIG; i++) begin
      if (op == OP_PASS)   tout[i] = tin[i];
      else if (err_o)      tout[i] = T_UNK;
      else                 tout[i] = enc_trit(sel_kn[i], sel_vl[i]);
      diff = diff | (tout[i] != tin[i]);
    end
    chg_o = (op != OP_PASS) && (err_o || diff);
  end

  assign a_out = tout[0];
  assign b_out = tout[1];
  assign z_out = tout[2];

  always_comb begin
    assert_err_blank_R5: assert (!err_o ||
        (a_out == T_UNK && b_out == T_UNK && z_out == T_UNK && chg_o))
      else $error("error result not blanked (R5)");
    if (op != OP_PASS)
      assert_no_bad_out_R1: assert (a_out != T_BAD && b_out != T_BAD && z_out != T_BAD)
        else $error("illegal code on output (R1)");
    if (op == OP_PASS)
      assert_pass_R7: assert (a_out == a_in && b_out == b_in && z_out == z_in && !err_o && !chg_o)
        else $error("pass-through altered (R7)");
    if (op != OP_PASS && a_in == T_UNK && b_in == T_UNK && z_in == T_UNK)
      assert_allx_R6: assert (!err_o && !chg_o && a_out == T_UNK && z_out == T_UNK)
        else $error("all-unknown not quiet (R6)");
    if (!err_o && a_in[1])
      assert_keep_a_R9: assert (a_out == a_in) else $error("known A overwritten (R9)");
    if (!err_o && z_in[1])
      assert_keep_z_R9: assert (z_out == z_in) else $error("known Z overwritten (R9)");
  end
endmodule

// File: tb/tb_tdl_cell.sv
`timescale 1ns/1ps
module tb_tdl_cell;
  logic       clk = 1'b0;
  logic [1:0] gate_op, a_in, b_in, z_in;
  logic [1:0] a_out, b_out, z_out;
  logic       err_o, chg_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  tdl_cell dut (.gate_op(gate_op), .a_in(a_in), .b_in(b_in), .z_in(z_in),
                .a_out(a_out), .b_out(b_out), .z_out(z_out),
                .err_o(err_o), .chg_o(chg_o));

  function automatic logic [1:0] dig2code(input int d);
    return (d == 0) ? 2'b00 : (d == 1) ? 2'b10 : 2'b11;
  endfunction

  function automatic logic gate_eval(input logic [1:0] op, input logic a, input logic b);
    case (op)
      2'd0: return a & b;
      2'd1: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  // Reference: {a,b,z codes, err, chg} by enumerating binary completions
  function automatic logic [7:0] ref_model(input logic [1:0] op, input logic [1:0] a,
                                           input logic [1:0] b, input logic [1:0] z);
    logic [1:0] c [3];
    logic [1:0] r [3];
    logic [2:0] seen0, seen1;
    logic       ok_any, e, ch;
    c[0] = a; c[1] = b; c[2] = z;
    if (op == 2'd3) return {a, b, z, 2'b00};
    seen0 = '0; seen1 = '0; ok_any = 1'b0;
    for (int m = 0; m < 8; m++) begin
      logic [2:0] bits;
      logic       ok;
      bits = 3'(m);
      ok = (gate_eval(op, bits[0], bits[1]) == bits[2]);
      for (int i = 0; i < 3; i++) begin
        if (c[i] == 2'b01) ok = 1'b0;
        if (c[i][1] && c[i][0] != bits[i]) ok = 1'b0;
      end
      if (ok) begin
        ok_any = 1'b1;
        for (int i = 0; i < 3; i++) begin
          if (bits[i]) seen1[i] = 1'b1; else seen0[i] = 1'b1;
        end
      end
    end
    e = !ok_any;
    ch = e;
    for (int i = 0; i < 3; i++) begin
      if (e) r[i] = 2'b00;
      else if (seen0[i] && !seen1[i]) r[i] = 2'b10;
      else if (seen1[i] && !seen0[i]) r[i] = 2'b11;
      else r[i] = 2'b00;
      if (r[i] != c[i]) ch = 1'b1;
    end
    return {r[0], r[1], r[2], e, ch};
  endfunction

  task automatic apply_check(input logic [1:0] op, input logic [1:0] a, input logic [1:0] b,
                             input logic [1:0] z, input string tag);
    logic [7:0] exp, act;
    @(negedge clk);
    gate_op = op; a_in = a; b_in = b; z_in = z;
    #1;
    exp = ref_model(op, a, b, z);
    act = {a_out, b_out, z_out, err_o, chg_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d in=%b_%b_%b actual=%b expected=%b", tag, op, a, b, z, act, exp);
    end
    // R9: known inputs kept when no error
    if (!exp[1] && op != 2'd3) begin
      n_chk++;
      if ((a[1] && a_out !== a) || (b[1] && b_out !== b) || (z[1] && z_out !== z)) begin
        n_bad++;
        $display("FAIL R9 actual=%b_%b_%b expected known kept from %b_%b_%b",
                 a_out, b_out, z_out, a, b, z);
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    gate_op = 2'd0; a_in = 2'b00; b_in = 2'b00; z_in = 2'b00;
    // Initial quiet state: all unknown, flags low (R6)
    apply_check(2'd0, 2'b00, 2'b00, 2'b00, "R6 all-unknown AND");
    apply_check(2'd2, 2'b00, 2'b00, 2'b00, "R6 all-unknown XOR");
    // Directed corners
    apply_check(2'd0, 2'b00, 2'b00, 2'b11, "R2 Z=1 forces inputs");
    apply_check(2'd0, 2'b11, 2'b00, 2'b10, "R2 A=1 Z=0 forces B=0");
    apply_check(2'd0, 2'b10, 2'b00, 2'b11, "R5 AND contradiction");
    apply_check(2'd1, 2'b00, 2'b00, 2'b10, "R3 Z=0 forces inputs");
    apply_check(2'd1, 2'b00, 2'b11, 2'b10, "R5 OR contradiction");
    apply_check(2'd2, 2'b11, 2'b00, 2'b00, "R4 single known no deduction");
    apply_check(2'd2, 2'b11, 2'b11, 2'b11, "R5 XOR odd parity");
    apply_check(2'd2, 2'b11, 2'b00, 2'b10, "R4 two known fix third");
    apply_check(2'd0, 2'b01, 2'b10, 2'b11, "R1 illegal code with contradiction");
    apply_check(2'd1, 2'b00, 2'b01, 2'b00, "R1 illegal code");
    apply_check(2'd3, 2'b01, 2'b11, 2'b10, "R7 pass-through");
    // Full sweep of legal triples for each function (R8)
    for (int op = 0; op < 4; op++) begin
      for (int t = 0; t < 27; t++) begin
        string tg;
        tg = (op == 0) ? "R2 R8" : (op == 1) ? "R3 R8" : (op == 2) ? "R4 R8" : "R7";
        apply_check(2'(op), dig2code(t % 3), dig2code((t / 3) % 3), dig2code(t / 9), tg);
      end
    end
    // Random raw codes, illegal ones included
    for (int k = 0; k < 400; k++) begin
      apply_check(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), "R1 R5 R8 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule